// File: doc/BRIEF.md
# Scan-Path Test Sequencer

This block pairs a small sequential circuit with the controller that tests it through a single scan chain. The circuit's state register is built from edge-triggered flip-flops, each with a two-way input multiplexer. With the mode select low, every flip-flop takes its functional next state. With it high, the flip-flops form one serial shift register from a scan-in bit to a scan-out bit. Outside a test run the circuit behaves as ordinary logic. Its next state is the current state rotated left by one, with the primary inputs XORed into the low bits.

A pulse on `start` launches a test run. The controller first proves the chain can carry both logic values, by flushing it with ones and then with zeros. It then loads the first pattern and repeats a loop: one functional capture clock, then an unload of the captured response. Each unload also shifts in the next pattern. A golden copy of the next-state function supplies the expected response. The first mismatch sets a sticky fail flag and records which pattern failed. Fault sites for a stuck chain cell or a stuck next-state bit are set by parameters, so a faulty copy can be built for qualification.

Top module: `scan_seq_top`

## Requirements
- R1: With `scan_mode` low, every clock loads the state register with the current state rotated left by one, XORed with the zero-extended test-input word. Outside a run that word is `func_in`. `func_out` always equals state bits [PI_W-1:0] XOR that word. Reset clears the state to zero. `scan_mode` is low whenever `busy` is low.
- R2: With `scan_mode` high, each clock shifts the chain by one place. `scan_si` enters bit 0, and `scan_so` shows bit N-1 without delay.
- R3: The clock edge that samples `start` high starts a run. The run begins with 2N clocks of `scan_si`=1 and then 2N clocks of `scan_si`=0. `scan_so` is compared with the flushed value during the last N clocks of each half.
- R4: After the flush, pattern 1 is shifted in over N clocks, highest state bit first. Pattern k uses h=(37k+11) mod 256. State bit i is h[i mod 8], and test-input bit j is h[7-j] (PI_W ≤ 8).
- R5: After each load, `scan_mode` is low for exactly one clock, and the test-input word is the current pattern's. In the next clock `scan_mode` is high again.
- R6: Each capture is followed by N shift clocks. In these clocks `scan_so` is compared, highest bit first, with the expected response (pattern state rotated left, XOR test inputs). At the same time `scan_si` carries the next pattern, highest bit first, or zeros after the last pattern.
- R7: `busy` stays high for exactly 5N + NPAT·(N+1) clocks. Then `done` rises, `busy` falls, and `pat_cnt` equals NPAT.
- R8: `fail` is sticky for the rest of the run. `fail_pat` holds the index of the first mismatching pattern, or 0 for a mismatch during the flush.
- R9: A chain cell stuck at 0 or at 1 is caught by the flush, which gives `fail`=1 and `fail_pat`=0. A stuck next-state bit passes the flush and is reported against the first pattern whose expected response differs at that bit.
- R10: `start` while `done` is high clears `fail` and runs the whole sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for chain and controller |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a test run when idle or done |
| func_in | input | PI_W | Primary inputs in functional operation |
| func_out | output | PI_W | Primary outputs: low state bits XOR test-input word |
| scan_mode | output | 1 | Chain mode select, high for shifting |
| scan_si | output | 1 | Bit entering chain position 0 |
| scan_so | output | 1 | Bit leaving chain position N-1 |
| busy | output | 1 | A test run is in progress |
| done | output | 1 | The run has finished |
| fail | output | 1 | Sticky mismatch flag |
| fail_pat | output | PW | Index of first failing pattern (0 = flush) |
| pat_cnt | output | PW | Patterns whose response has been compared |

## Verification
A wrong controller state shows up at once on `scan_mode` or `scan_si`, because the bench predicts both for every clock of the run. A phase that is off by one clock therefore fails at its first boundary. A corrupted chain bit appears on `scan_so` within N clocks, either in the second half of a flush or in the next unload. A bad pattern counter shows up as a wrong `scan_si` stream during the following unload, or as a wrong `pat_cnt` or busy length at the end of the run. Faulty copies built with stuck chain cells and a stuck next-state bit check that the fail flag and the recorded index point where they should.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FLUSH1,
    ST_FLUSH0,
    ST_LOAD,
    ST_CAPTURE,
    ST_UNLD_LD,
    ST_DONE
  } seq_st_t;
endpackage

// File: rtl/scan_cell.sv
module scan_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic mode,
  input  logic func_d,
  input  logic chain_d,
  output logic q
);
  logic d_sel;

  always_comb d_sel = mode ? chain_d : func_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= d_sel;
  end
endmodule

// File: rtl/scan_chain.sv
module scan_chain #(
  parameter int   N          = 12,
  parameter int   CELL_FAULT = -1,
  parameter logic FAULT_VAL  = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode,
  input  logic         si,
  input  logic [N-1:0] nxt,
  output logic [N-1:0] q,
  output logic         so
);
  logic [N-1:0] chain_d;
  logic [N-1:0] q_raw;

  for (genvar gi = 0; gi < N; gi++) begin : g_cell
    if (gi == 0) begin : g_head
      assign chain_d[gi] = si;
    end else begin : g_link
      assign chain_d[gi] = q[gi-1];
    end

    scan_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (mode),
      .func_d  (nxt[gi]),
      .chain_d (chain_d[gi]),
      .q       (q_raw[gi])
    );

    if (gi == CELL_FAULT) begin : g_stuck
      assign q[gi] = FAULT_VAL;
    end else begin : g_clean
      assign q[gi] = q_raw[gi];
    end
  end

  assign so = q[N-1];
endmodule

// File: rtl/cut_next.sv
module cut_next #(
  parameter int   N         = 12,
  parameter int   PI_W      = 4,
  parameter int   NS_FAULT  = -1,
  parameter logic FAULT_VAL = 1'b0
) (
  input  logic [N-1:0]    st,
  input  logic [PI_W-1:0] pin,
  output logic [N-1:0]    nxt
);
  logic [N-1:0] nxt_raw;

  always_comb nxt_raw = {st[N-2:0], st[N-1]} ^ N'(pin);

  for (genvar gi = 0; gi < N; gi++) begin : g_bit
    if (gi == NS_FAULT) begin : g_stuck
      assign nxt[gi] = FAULT_VAL;
    end else begin : g_clean
      assign nxt[gi] = nxt_raw[gi];
    end
  end
endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_pkg::*;
#(
  parameter int N    = 12,
  parameter int PI_W = 4,
  parameter int NPAT = 6,
  localparam int PW  = $clog2(NPAT + 1),
  localparam int CW  = $clog2(2 * N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            so,
  input  logic [N-1:0]    exp_st,
  output logic            mode,
  output logic            si,
  output logic            capture,
  output logic [N-1:0]    pat_cur,
  output logic [PI_W-1:0] pi_cur,
  output logic            busy,
  output logic            done,
  output logic            fail,
  output logic [PW-1:0]   fail_pat,
  output logic [PW-1:0]   pat_cnt
);
  seq_st_t       st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [PW-1:0] pidx_q, pidx_n;
  logic [PW-1:0] pcnt_q, pcnt_n;
  logic [PW-1:0] fpat_q, fpat_n;
  logic          fail_q, fail_n;
  logic [7:0]    h_cur, h_nxt;
  logic [N-1:0]  pat_nxt;
  logic          chk_en, chk_bit, mism;
  logic          last_shift, last_flush, upper_half, last_pat;

  function automatic logic [7:0] hsh(input logic [15:0] k);
    logic [15:0] m;
    m = k * 16'd37 + 16'd11;
    return m[7:0];
  endfunction

  // bit selected MSB first: shift count c addresses bit N-1-c
  function automatic logic pick(input logic [N-1:0] v, input logic [CW-1:0] c);
    logic r;
    r = 1'b0;
    for (int i = 0; i < N; i++)
      if (c == CW'(N - 1 - i)) r = v[i];
    return r;
  endfunction

  always_comb begin
    h_cur = hsh(16'(pidx_q));
    h_nxt = hsh(16'(pidx_q) + 16'd1);
    for (int i = 0; i < N; i++) begin
      pat_cur[i] = h_cur[i % 8];
      pat_nxt[i] = h_nxt[i % 8];
    end
    for (int j = 0; j < PI_W; j++) pi_cur[j] = h_cur[7 - j];
  end

  always_comb begin
    last_shift = (cnt_q == CW'(N - 1));
    last_flush = (cnt_q == CW'(2 * N - 1));
    upper_half = (cnt_q >= CW'(N));
    last_pat   = (pidx_q == PW'(NPAT));
    mode       = (st_q == ST_FLUSH1) || (st_q == ST_FLUSH0) ||
                 (st_q == ST_LOAD)   || (st_q == ST_UNLD_LD);
    capture    = (st_q == ST_CAPTURE);
    busy       = (st_q != ST_IDLE) && (st_q != ST_DONE);
    done       = (st_q == ST_DONE);
    si         = 1'b0;
    chk_en     = 1'b0;
    chk_bit    = 1'b0;
    case (st_q)
      ST_FLUSH1:  begin si = 1'b1; chk_en = upper_half; chk_bit = 1'b1; end
      ST_FLUSH0:  begin chk_en = upper_half; end
      ST_LOAD:    si = pick(pat_cur, cnt_q);
      ST_UNLD_LD: begin
        si      = last_pat ? 1'b0 : pick(pat_nxt, cnt_q);
        chk_en  = 1'b1;
        chk_bit = pick(exp_st, cnt_q);
      end
      default: ;
    endcase
    mism = chk_en && (so != chk_bit);
  end

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    pidx_n = pidx_q;
    pcnt_n = pcnt_q;
    fail_n = fail_q;
    fpat_n = fpat_q;
    if (mism && !fail_q) begin
      fail_n = 1'b1;
      fpat_n = pidx_q;
    end
    case (st_q)
      ST_IDLE, ST_DONE: if (start) begin
        st_n   = ST_FLUSH1;
        cnt_n  = '0;
        pidx_n = '0;
        pcnt_n = '0;
        fail_n = 1'b0;
        fpat_n = '0;
      end
      ST_FLUSH1: begin
        cnt_n = cnt_q + 1'b1;
        if (last_flush) begin st_n = ST_FLUSH0; cnt_n = '0; end
      end
      ST_FLUSH0: begin
        cnt_n = cnt_q + 1'b1;
        if (last_flush) begin st_n = ST_LOAD; cnt_n = '0; pidx_n = PW'(1); end
      end
      ST_LOAD: begin
        cnt_n = cnt_q + 1'b1;
        if (last_shift) begin st_n = ST_CAPTURE; cnt_n = '0; end
      end
      ST_CAPTURE: st_n = ST_UNLD_LD;
      ST_UNLD_LD: begin
        cnt_n = cnt_q + 1'b1;
        if (last_shift) begin
          cnt_n  = '0;
          pcnt_n = pcnt_q + 1'b1;
          if (last_pat) st_n = ST_DONE;
          else begin st_n = ST_CAPTURE; pidx_n = pidx_q + 1'b1; end
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      pidx_q <= '0;
      pcnt_q <= '0;
      fail_q <= 1'b0;
      fpat_q <= '0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      pidx_q <= pidx_n;
      pcnt_q <= pcnt_n;
      fail_q <= fail_n;
      fpat_q <= fpat_n;
    end
  end

  assign fail     = fail_q;
  assign fail_pat = fpat_q;
  assign pat_cnt  = pcnt_q;
endmodule

// File: rtl/scan_seq_top.sv
module scan_seq_top #(
  parameter int   N          = 12,
  parameter int   PI_W       = 4,
  parameter int   NPAT       = 6,
  parameter int   CELL_FAULT = -1,
  parameter int   NS_FAULT   = -1,
  parameter logic FAULT_VAL  = 1'b0,
  localparam int  PW         = $clog2(NPAT + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [PI_W-1:0] func_in,
  output logic [PI_W-1:0] func_out,
  output logic            scan_mode,
  output logic            scan_si,
  output logic            scan_so,
  output logic            busy,
  output logic            done,
  output logic            fail,
  output logic [PW-1:0]   fail_pat,
  output logic [PW-1:0]   pat_cnt
);
  logic [N-1:0]    st, nxt, pat_cur, exp_st;
  logic [PI_W-1:0] pi_cur, pi_eff;
  logic            capture;

  assign pi_eff   = capture ? pi_cur : func_in;
  assign func_out = st[PI_W-1:0] ^ pi_eff;

  scan_chain #(.N(N), .CELL_FAULT(CELL_FAULT), .FAULT_VAL(FAULT_VAL)) u_chain (
    .clk   (clk),
    .rst_n (rst_n),
    .mode  (scan_mode),
    .si    (scan_si),
    .nxt   (nxt),
    .q     (st),
    .so    (scan_so)
  );

  cut_next #(.N(N), .PI_W(PI_W), .NS_FAULT(NS_FAULT), .FAULT_VAL(FAULT_VAL)) u_cut (
    .st  (st),
    .pin (pi_eff),
    .nxt (nxt)
  );

  cut_next #(.N(N), .PI_W(PI_W), .NS_FAULT(-1), .FAULT_VAL(1'b0)) u_gold (
    .st  (pat_cur),
    .pin (pi_cur),
    .nxt (exp_st)
  );

  scan_ctrl #(.N(N), .PI_W(PI_W), .NPAT(NPAT)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .so       (scan_so),
    .exp_st   (exp_st),
    .mode     (scan_mode),
    .si       (scan_si),
    .capture  (capture),
    .pat_cur  (pat_cur),
    .pi_cur   (pi_cur),
    .busy     (busy),
    .done     (done),
    .fail     (fail),
    .fail_pat (fail_pat),
    .pat_cnt  (pat_cnt)
  );
endmodule

// File: rtl/scan_seq_chk.sv
module scan_seq_chk #(
  parameter int  NPAT = 6,
  localparam int PW   = $clog2(NPAT + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          scan_mode,
  input logic          fail,
  input logic [PW-1:0] fail_pat,
  input logic [PW-1:0] pat_cnt
);
  AST_IDLE_FUNCTIONAL: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !scan_mode); // R1
  AST_CAPTURE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !scan_mode) |=> scan_mode); // R5
  AST_PATCNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    pat_cnt <= PW'(NPAT)); // R7
  AST_DONE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (pat_cnt == PW'(NPAT))); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R7
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fail) |=> fail); // R8
  AST_FAILPAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fail) |=> $stable(fail_pat)); // R8
endmodule

bind scan_seq_top scan_seq_chk #(.NPAT(NPAT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .scan_mode (scan_mode),
  .fail      (fail),
  .fail_pat  (fail_pat),
  .pat_cnt   (pat_cnt)
);

// File: tb/scan_seq_top_test.sv
`timescale 1ns/1ps
module scan_seq_top_test;
  localparam int N     = 12;
  localparam int PI_W  = 4;
  localparam int NPAT  = 6;
  localparam int PW    = $clog2(NPAT + 1);
  localparam int TOTAL = 5 * N + NPAT * (N + 1);
  localparam int NSB   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [PI_W-1:0] func_in = '0;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  logic [PI_W-1:0] fo, fo0, fo1, fo2;
  logic sm, ssi, sso, bsy, dn, fl;
  logic [PW-1:0] fp, pc;
  logic sm0, ssi0, sso0, bsy0, dn0, fl0; logic [PW-1:0] fp0, pc0;
  logic sm1, ssi1, sso1, bsy1, dn1, fl1; logic [PW-1:0] fp1, pc1;
  logic sm2, ssi2, sso2, bsy2, dn2, fl2; logic [PW-1:0] fp2, pc2;

  scan_seq_top #(.N(N), .PI_W(PI_W), .NPAT(NPAT)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .func_in(func_in), .func_out(fo),
    .scan_mode(sm), .scan_si(ssi), .scan_so(sso), .busy(bsy), .done(dn),
    .fail(fl), .fail_pat(fp), .pat_cnt(pc));

  scan_seq_top #(.N(N), .PI_W(PI_W), .NPAT(NPAT), .CELL_FAULT(5), .FAULT_VAL(1'b0)) uut_sa0 (
    .clk(clk), .rst_n(rst_n), .start(start), .func_in(func_in), .func_out(fo0),
    .scan_mode(sm0), .scan_si(ssi0), .scan_so(sso0), .busy(bsy0), .done(dn0),
    .fail(fl0), .fail_pat(fp0), .pat_cnt(pc0));

  scan_seq_top #(.N(N), .PI_W(PI_W), .NPAT(NPAT), .CELL_FAULT(0), .FAULT_VAL(1'b1)) uut_sa1 (
    .clk(clk), .rst_n(rst_n), .start(start), .func_in(func_in), .func_out(fo1),
    .scan_mode(sm1), .scan_si(ssi1), .scan_so(sso1), .busy(bsy1), .done(dn1),
    .fail(fl1), .fail_pat(fp1), .pat_cnt(pc1));

  scan_seq_top #(.N(N), .PI_W(PI_W), .NPAT(NPAT), .NS_FAULT(NSB), .FAULT_VAL(1'b1)) uut_ns (
    .clk(clk), .rst_n(rst_n), .start(start), .func_in(func_in), .func_out(fo2),
    .scan_mode(sm2), .scan_si(ssi2), .scan_so(sso2), .busy(bsy2), .done(dn2),
    .fail(fl2), .fail_pat(fp2), .pat_cnt(pc2));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] hv(input int k);
    return 8'((37 * k + 11) % 256);
  endfunction

  function automatic logic [N-1:0] pat_of(input int k);
    logic [N-1:0] p;
    logic [7:0] h;
    h = hv(k);
    for (int i = 0; i < N; i++) p[i] = h[i % 8];
    return p;
  endfunction

  function automatic logic [PI_W-1:0] tin_of(input int k);
    logic [PI_W-1:0] t;
    logic [7:0] h;
    h = hv(k);
    for (int j = 0; j < PI_W; j++) t[j] = h[7 - j];
    return t;
  endfunction

  function automatic logic [N-1:0] resp_of(input int k);
    logic [N-1:0] p;
    p = pat_of(k);
    return {p[N-2:0], p[N-1]} ^ N'(tin_of(k));
  endfunction

  task automatic t_reset_state;
    @(negedge clk);
    chk(!sm && !bsy && !dn && !fl, "R1 reset mode/busy/done/fail", {sm, bsy, dn, fl}, 0);
    chk(pc == '0, "R7 reset pat_cnt", int'(pc), 0);
    chk(fo == func_in, "R1 reset state zero", int'(fo), int'(func_in));
  endtask

  task automatic t_functional;
    logic [N-1:0] s;
    int errs;
    s = '0;
    errs = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      func_in = PI_W'((i * 7 + 3) % 16);
      #1;
      if (fo != (s[PI_W-1:0] ^ func_in) || sm) errs++;
      @(posedge clk);
      s = {s[N-2:0], s[N-1]} ^ N'(func_in);
    end
    chk(errs == 0, "R1 functional next state and outputs", errs, 0);
    @(negedge clk);
    func_in = '0;
  endtask

  task automatic t_scan_run;
    int e_fl, e_ld, e_cap, e_un, e_bsy, e_fail;
    e_fl = 0; e_ld = 0; e_cap = 0; e_un = 0; e_bsy = 0; e_fail = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int c = 0; c < TOTAL; c++) begin
      if (!bsy || dn) e_bsy++;
      if (fl) e_fail++;
      if (c < 2 * N) begin
        if (!sm || ssi != 1'b1) e_fl++;
        if (c >= N && sso != 1'b1) e_fl++;
      end else if (c < 4 * N) begin
        if (!sm || ssi != 1'b0) e_fl++;
        if (c >= 3 * N && sso != 1'b0) e_fl++;
      end else if (c < 5 * N) begin
        if (!sm || ssi != pat_of(1)[N - 1 - (c - 4 * N)]) e_ld++;
      end else begin
        int r, p, w, b;
        logic exp_si;
        r = c - 5 * N;
        p = r / (N + 1) + 1;
        w = r % (N + 1);
        if (w == 0) begin
          if (sm) e_cap++;
        end else begin
          b = N - w;
          exp_si = (p < NPAT) ? pat_of(p + 1)[b] : 1'b0;
          if (!sm) e_cap++;
          if (sso != resp_of(p)[b]) e_un++;
          if (ssi != exp_si) e_un++;
        end
      end
      @(negedge clk);
    end
    chk(e_fl == 0, "R2/R3 flush stream and compare", e_fl, 0);
    chk(e_ld == 0, "R4 first pattern load order", e_ld, 0);
    chk(e_cap == 0, "R5 single capture clock per pattern", e_cap, 0);
    chk(e_un == 0, "R6 overlapped unload and load", e_un, 0);
    chk(e_bsy == 0, "R7 busy throughout run", e_bsy, 0);
    chk(dn && !bsy, "R7 done after exact run length", {dn, bsy}, 2);
    chk(pc == PW'(NPAT), "R7 pattern count", int'(pc), NPAT);
    chk(e_fail == 0 && !fl, "R8 fault-free run passes", e_fail, 0);
  endtask

  task automatic t_fault_results;
    int first;
    first = 0;
    for (int k = NPAT; k >= 1; k--)
      if (resp_of(k)[NSB] != 1'b1) first = k;
    chk(fl0 && fp0 == '0, "R9 stuck-at-0 chain cell caught in flush", {fl0, fp0}, 8);
    chk(fl1 && fp1 == '0, "R9 stuck-at-1 chain cell caught in flush", {fl1, fp1}, 8);
    chk(fl2 == (first != 0), "R9 next-state fault flagged", int'(fl2), int'(first != 0));
    chk(int'(fp2) == first, "R8 first failing pattern index", int'(fp2), first);
    chk(dn0 && dn1 && dn2, "R7 faulty copies also finish", {dn0, dn1, dn2}, 7);
  endtask

  task automatic t_restart;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(!fl0 && bsy0, "R10 restart clears fail", {fl0, bsy0}, 1);
    while (!dn) @(negedge clk);
    chk(fl0 && fp0 == '0, "R10 rerun flags fault again", {fl0, fp0}, 8);
    chk(!fl && pc == PW'(NPAT), "R10 rerun passes on clean copy", {fl, pc}, NPAT);
  endtask

  initial begin
    #(8 * 200000);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_functional();
    t_scan_run();
    t_fault_results();
    t_restart();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule